// File: doc/BRIEF.md
# Half-Bridge Gate Drive Sequencer

This block is the clocked control core of a synchronous buck power stage. It accepts a PWM command that has already been resolved into one of three levels (high, low, or the mid window between them), together with an enable, a supply-good flag, a conduction-mode select, a zero-current flag from the inductor sense path and one off-sense flag per gate. From these it decides, once per clock, which of the two switch gates (high-side or low-side) may be driven.

The sequencer never lets both gates conduct at the same time. A change of command first removes the gate that is on. The other gate turns on once its partner is sensed off, or after a timeout that acts as a fallback fixed dead time. A mid-window level that lasts longer than a programmable hold-off parks both gates off. A shorter one is treated as the previous level. In diode-emulation mode the low-side gate is released when the inductor current reaches zero, but never before a minimum on-time. A low enable, a missing supply or a parked mid window removes both gates in the same cycle.

Top module: `hb_gate_sequencer`

## Requirements
- R1: While `supply_ok_i` is 0, both gate outputs are 0 in that same cycle, and the next clock edge puts the sequencer in the off state.
- R2: While `enable_i` is 0, both gate outputs are 0 in that same cycle, whatever `pwm_lvl_i` is, and the next clock edge puts the sequencer in the off state.
- R3: When the command turns high while the low-side gate is on, the low-side gate drops at the next edge. The high-side gate rises at the first edge at which `ls_off_sense_i` is sampled 1.
- R4: When the command turns low while the high-side gate is on, the high-side gate drops at the next edge. The low-side gate rises at the first edge at which `hs_off_sense_i` is sampled 1.
- R5: `pwm_lvl_i` codes are 2'b00 low, 2'b01 high, and 2'b10 or 2'b11 mid. When mid is sampled on `HOLDOFF_CYC` consecutive edges, both gates are 0 from that edge on, and the sequencer enters the off state at the following edge.
- R6: When `pwm_lvl_i` leaves a parked mid window, the new level is acted on at the first edge. From the off state, the gate for that level turns on at once if its partner is sensed off.
- R7: With `cont_mode_i` = 0, the low-side gate stays on for at least `MIN_ON_CYC` cycles. It turns off at the first edge after that at which `zero_cur_i` is 1. The sequencer then idles with both gates off until the command turns high.
- R8: With `cont_mode_i` = 1, the low-side gate stays on for the whole low command and `zero_cur_i` has no effect.
- R9: A change of `cont_mode_i` is acted on at the next edge, including in the middle of a low-side interval or while idling in emulation mode.
- R10: A mid level sampled on fewer than `HOLDOFF_CYC` consecutive edges leaves the previous high or low command in force, and the gate outputs do not change.
- R11: If the awaited off-sense flag stays 0, the waiting gate turns on after `DT_TIMEOUT_CYC` cycles in the wait state.
- R12: `hs_gate_o` and `ls_gate_o` are never 1 in the same cycle.
- R13: After reset both gates are 0 and `state_o` is 0. The `state_o` codes are: 0 off, 1 waiting to turn on the high-side gate, 2 high-side on, 3 waiting to turn on the low-side gate, 4 low-side on, 5 emulation idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_lvl_i | input | 2 | Resolved PWM level: 00 low, 01 high, 1x mid window |
| enable_i | input | 1 | 1 allows switching, 0 forces both gates off |
| supply_ok_i | input | 1 | Driver supply above its undervoltage threshold |
| cont_mode_i | input | 1 | 1 forces continuous conduction, 0 allows diode emulation |
| zero_cur_i | input | 1 | Inductor current has reached zero |
| hs_off_sense_i | input | 1 | High-side gate sensed off |
| ls_off_sense_i | input | 1 | Low-side gate sensed off |
| hs_gate_o | output | 1 | High-side gate enable |
| ls_gate_o | output | 1 | Low-side gate enable |
| state_o | output | 3 | Sequencer state code (see R13) |

## Verification
Forcing inputs (enable, supply, a parked mid window) remove the gates in the cycle they are applied. The bench therefore also samples those cases one time unit after driving, before any clock edge. Sequencing decisions appear one edge after the inputs that cause them. The hold-off, minimum on-time and dead-time timeout expire at a known count of edges after their start. The bench drives inputs on falling edges and samples one time unit after the rising edge on which each result is due, never earlier or later. The short parameter values used by the bench make each of those windows a handful of edges long, so the checks on both sides of each boundary can be counted explicitly.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;
  typedef enum logic [2:0] {
    ST_OFF      = 3'd0,
    ST_WAIT_HS  = 3'd1,
    ST_HS_ON    = 3'd2,
    ST_WAIT_LS  = 3'd3,
    ST_LS_ON    = 3'd4,
    ST_DCM_IDLE = 3'd5
  } hb_state_e;
endpackage

// File: rtl/hb_mid_filter.sv
module hb_mid_filter #(
  parameter int unsigned HOLDOFF_CYC = 15,
  localparam int unsigned CW = $clog2(HOLDOFF_CYC + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] pwm_lvl_i,
  output logic       cmd_hi_o,
  output logic       tri_off_o
);
  localparam logic [CW-1:0] CNT_END = CW'(HOLDOFF_CYC);

  logic          is_mid;
  logic          held_hi_q;
  logic [CW-1:0] mid_cnt_q;

  assign is_mid = pwm_lvl_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_hi_q <= 1'b0;
      mid_cnt_q <= '0;
    end else if (is_mid) begin
      if (mid_cnt_q < CNT_END) mid_cnt_q <= mid_cnt_q + 1'b1;
    end else begin
      mid_cnt_q <= '0;
      held_hi_q <= pwm_lvl_i[0];
    end
  end

  // short mid window keeps last level
  assign cmd_hi_o  = is_mid ? held_hi_q : pwm_lvl_i[0];
  assign tri_off_o = is_mid && (mid_cnt_q == CNT_END);

  AST_TRI_AFTER_MID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tri_off_o |-> $past(is_mid)) else $error("tri-state without prior mid"); // R5
  AST_SHORT_MID_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_mid && !tri_off_o && $past(rst_ni)) |-> (cmd_hi_o == $past(cmd_hi_o)))
    else $error("short mid changed command"); // R10
endmodule

// File: rtl/hb_dwell_cnt.sv
module hb_dwell_cnt #(
  parameter int unsigned MAX_CNT = 35,
  localparam int unsigned CW = $clog2(MAX_CNT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] CNT_TOP = CW'(MAX_CNT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (cnt_q < CNT_TOP) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= CNT_TOP) else $error("dwell count overflow"); // R11
  AST_CNT_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr_i) |-> (cnt_o == '0)) else $error("dwell count not cleared"); // R7
endmodule

// File: rtl/hb_gate_sequencer.sv
module hb_gate_sequencer
  import hb_gate_pkg::*;
#(
  parameter int unsigned HOLDOFF_CYC    = 15,
  parameter int unsigned MIN_ON_CYC     = 35,
  parameter int unsigned DT_TIMEOUT_CYC = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] pwm_lvl_i,
  input  logic       enable_i,
  input  logic       supply_ok_i,
  input  logic       cont_mode_i,
  input  logic       zero_cur_i,
  input  logic       hs_off_sense_i,
  input  logic       ls_off_sense_i,
  output logic       hs_gate_o,
  output logic       ls_gate_o,
  output logic [2:0] state_o
);
  localparam int unsigned TMR_MAX = (MIN_ON_CYC > DT_TIMEOUT_CYC) ? MIN_ON_CYC : DT_TIMEOUT_CYC;
  localparam int unsigned TW      = $clog2(TMR_MAX + 1);
  localparam logic [TW-1:0] MIN_LAST = TW'(MIN_ON_CYC - 1);
  localparam logic [TW-1:0] DT_LAST  = TW'(DT_TIMEOUT_CYC - 1);

  hb_state_e     state_q, state_d;
  logic          cmd_hi, tri_off, force_off, gate_ok;
  logic          dt_done, min_done, tmr_clr;
  logic [TW-1:0] tmr;

  hb_mid_filter #(.HOLDOFF_CYC(HOLDOFF_CYC)) u_filt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pwm_lvl_i (pwm_lvl_i),
    .cmd_hi_o  (cmd_hi),
    .tri_off_o (tri_off)
  );

  hb_dwell_cnt #(.MAX_CNT(TMR_MAX)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (tmr_clr),
    .cnt_o  (tmr)
  );

  assign force_off = !supply_ok_i || !enable_i || tri_off;
  assign dt_done   = (tmr >= DT_LAST);
  assign min_done  = (tmr >= MIN_LAST);

  always_comb begin
    state_d = state_q;
    if (force_off) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF, ST_DCM_IDLE: begin
          if (cmd_hi)
            state_d = ls_off_sense_i ? ST_HS_ON : ST_WAIT_HS;
          else if (state_q == ST_OFF || cont_mode_i)
            state_d = hs_off_sense_i ? ST_LS_ON : ST_WAIT_LS;
        end
        ST_WAIT_HS: begin
          if (!cmd_hi)                       state_d = ST_WAIT_LS;
          else if (ls_off_sense_i || dt_done) state_d = ST_HS_ON;
        end
        ST_HS_ON: begin
          if (!cmd_hi) state_d = ST_WAIT_LS;
        end
        ST_WAIT_LS: begin
          if (cmd_hi)                         state_d = ST_WAIT_HS;
          else if (hs_off_sense_i || dt_done) state_d = ST_LS_ON;
        end
        ST_LS_ON: begin
          if (cmd_hi)                                       state_d = ST_WAIT_HS;
          else if (!cont_mode_i && zero_cur_i && min_done) state_d = ST_DCM_IDLE;
        end
        default: state_d = ST_OFF;
      endcase
    end
  end

  assign tmr_clr = (state_d != state_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_OFF;
    else         state_q <= state_d;
  end

  // forcing conditions act in the same cycle
  assign gate_ok   = !force_off;
  assign hs_gate_o = gate_ok && (state_q == ST_HS_ON);
  assign ls_gate_o = gate_ok && (state_q == ST_LS_ON);
  assign state_o   = state_q;

  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_gate_o && ls_gate_o)) else $error("both gates on"); // R12
  AST_SUPPLY_PARKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> (state_o == 3'd0)) else $error("supply loss not parked"); // R1
  AST_ENABLE_PARKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (state_o == 3'd0)) else $error("disable not parked"); // R2
  AST_HS_AFTER_LS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_gate_o) |-> !$past(ls_gate_o)) else $error("hs on while ls on"); // R3
  AST_LS_AFTER_HS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_gate_o) |-> !$past(hs_gate_o)) else $error("ls on while hs on"); // R4
  AST_MIN_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == ST_LS_ON && state_q == ST_DCM_IDLE) |-> ($past(tmr) >= MIN_LAST))
    else $error("low side released early"); // R7
  AST_CCM_NO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == ST_LS_ON && state_q == ST_DCM_IDLE) |-> !$past(cont_mode_i))
    else $error("zero current honoured in continuous mode"); // R8
  AST_DT_FALLBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == ST_WAIT_HS && state_q == ST_HS_ON)
      |-> ($past(ls_off_sense_i) || $past(tmr) >= DT_LAST))
    else $error("hs on without sense or timeout"); // R11
endmodule

// File: tb/tb_hb_gate_sequencer.sv
module tb_hb_gate_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int HO = 4;
  localparam int MO = 5;
  localparam int DT = 3;
  localparam logic [1:0] P_LO = 2'b00, P_HI = 2'b01, P_MID = 2'b10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] pwm = P_LO;
  logic       en = 1'b0, ok = 1'b0, cm = 1'b1, zc = 1'b0, hss = 1'b1, lss = 1'b1;
  logic       hs, ls;
  logic [2:0] st;
  int         nchk = 0, nfail = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hb_gate_sequencer #(.HOLDOFF_CYC(HO), .MIN_ON_CYC(MO), .DT_TIMEOUT_CYC(DT)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .pwm_lvl_i(pwm), .enable_i(en), .supply_ok_i(ok),
    .cont_mode_i(cm), .zero_cur_i(zc), .hs_off_sense_i(hss), .ls_off_sense_i(lss),
    .hs_gate_o(hs), .ls_gate_o(ls), .state_o(st)
  );

  // {pwm[1:0], en, ok, cm, zc, hss, lss, exp_hs, exp_ls}
  localparam logic [9:0] VEC [12] = '{
    10'b00_1_0_1_0_1_1_0_0,  // R1 no supply, low cmd
    10'b01_1_0_1_0_1_1_0_0,  // R1 no supply, high cmd
    10'b00_1_1_1_0_1_1_0_1,  // R4 start on low side
    10'b01_1_1_1_0_1_0_0_0,  // R3 low side drops first
    10'b01_1_1_1_0_1_0_0_0,  // R3 waits for ls sense
    10'b01_1_1_1_0_0_1_1_0,  // R3 hs on after sense
    10'b00_1_1_1_0_0_1_0_0,  // R4 hs drops first
    10'b00_1_1_1_0_1_1_0_1,  // R4 ls on after sense
    10'b00_1_1_1_1_1_1_0_1,  // R8 zero current ignored
    10'b00_1_1_1_1_1_1_0_1,  // R8
    10'b00_0_1_1_1_1_1_0_0,  // R2 disabled
    10'b00_1_1_1_1_1_1_0_1   // R2 re-enabled
  };

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic int gates();
    return {30'd0, hs, ls};
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk("R13 reset gates", gates(), 0);
    chk("R13 reset state", int'(st), 0);

    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      {pwm, en, ok, cm, zc, hss, lss} = VEC[i][9:2];
      step();
      chk($sformatf("R1-R4,R8 vector %0d (R1 R2 R3 R4 R8)", i), gates(), int'(VEC[i][1:0]));
    end

    // R2: disable acts within the cycle
    @(negedge clk); en = 1'b0; #1;
    chk("R2 same-cycle off", gates(), 0);
    step(); chk("R2 state off", int'(st), 0);
    @(negedge clk); en = 1'b1;
    step(); chk("R2 resume ls", gates(), 1);

    // R8: long continuous low interval with zero current
    for (int k = 0; k < 8; k++) begin
      step(); chk("R8 ls held", gates(), 1);
    end
    // R9: switch to emulation mid-interval
    @(negedge clk); cm = 1'b0;
    step(); chk("R9 ls off on mode change", gates(), 0);
    chk("R9 idle state", int'(st), 5);
    @(negedge clk); cm = 1'b1;
    step(); chk("R9 ls back on in continuous", gates(), 1);

    // R3: to high side
    @(negedge clk); pwm = P_HI;
    step(); chk("R3 ls drops", gates(), 0);
    step(); chk("R3 hs on", gates(), 2);

    // R10: short mid window
    @(negedge clk); pwm = P_MID;
    for (int k = 0; k < HO - 1; k++) begin
      step(); chk("R10 hs held in short mid", gates(), 2);
    end
    @(negedge clk); pwm = P_HI;
    step(); chk("R10 hs after short mid", gates(), 2);

    // R5: parked mid window
    @(negedge clk); pwm = P_MID;
    for (int k = 0; k < HO - 1; k++) begin
      step(); chk("R5 hs before holdoff", gates(), 2);
    end
    step(); chk("R5 off at holdoff", gates(), 0);
    step(); chk("R5 state off", int'(st), 0);
    for (int k = 0; k < 3; k++) begin
      step(); chk("R5 stays off", gates(), 0);
    end

    // R6: leave mid to low
    @(negedge clk); pwm = P_LO; #1;
    chk("R6 still off before edge", gates(), 0);
    step(); chk("R6 ls on first edge", gates(), 1);

    // R7: minimum on-time in emulation
    @(negedge clk); pwm = P_HI;
    step(); step(); chk("R7 setup hs", gates(), 2);
    @(negedge clk); pwm = P_LO; cm = 1'b0; zc = 1'b1;
    step(); chk("R7 wait ls", gates(), 0);
    step(); chk("R7 ls on", gates(), 1);
    for (int k = 1; k < MO; k++) begin
      step(); chk("R7 ls held for min on", gates(), 1);
    end
    step(); chk("R7 ls off after min on", gates(), 0);
    chk("R7 idle state", int'(st), 5);

    // R7: without zero current the low side stays on
    @(negedge clk); pwm = P_HI;
    step(); chk("R7 hs from idle", gates(), 2);
    @(negedge clk); pwm = P_LO; zc = 1'b0;
    step(); step(); chk("R7 ls on again", gates(), 1);
    for (int k = 0; k < 8; k++) begin
      step(); chk("R7 ls held without zero current", gates(), 1);
    end
    @(negedge clk); zc = 1'b1;
    step(); chk("R7 ls off at zero current", gates(), 0);

    // R11: dead-time fallback on both sides
    @(negedge clk); cm = 1'b1; lss = 1'b0;
    step(); chk("R11 setup ls", gates(), 1);
    @(negedge clk); pwm = P_HI;
    for (int k = 0; k < DT; k++) begin
      step(); chk("R11 hs waiting", gates(), 0);
    end
    step(); chk("R11 hs on by timeout", gates(), 2);
    @(negedge clk); pwm = P_LO; hss = 1'b0;
    for (int k = 0; k < DT; k++) begin
      step(); chk("R11 ls waiting", gates(), 0);
    end
    step(); chk("R11 ls on by timeout", gates(), 1);

    // R1: supply loss
    @(negedge clk); ok = 1'b0; #1;
    chk("R1 same-cycle off", gates(), 0);
    step(); chk("R1 state off", int'(st), 0);
    chk("R12 no overlap at end", int'(hs && ls), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule